// File: doc/BRIEF.md
# UART interrupt status and enable unit

This block turns the raw event sources of a serial port into one interrupt line. Each cycle it takes in the transmit FIFO fill level and a threshold selector. It also takes two receive conditions: data at or above the receive trigger level, and receive inactivity timeout. Three error events arrive as single-cycle pulses: framing error, break received and receive overrun. A seven-bit status word shows all of these to software.

The transmit request and the three error bits are sticky. They stay set until software writes a one to their position through the clear port. The two receive bits follow their conditions and drop when the condition goes away. A control write loads three group enables: transmit, receive, and a shared error enable. The interrupt output is the registered OR of each group's pending status gated by that group's enable.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is high, the status word, the three enables and the interrupt output all go to zero on the next clock edge.
- R2: Status bit 0 (transmit request) is set by the clock edge at which the sampled transmit level is at or below the selected threshold, provided the level sampled at the previous edge was above it. Threshold codes on the 2-bit selector: 0 = empty (0), 1 = 4, 2 = 8, 3 = 16 characters. After reset the previous sample counts as below. The bit stays set until cleared.
- R3: Status bit 1 equals the receive trigger condition and bit 2 equals the receive timeout condition, each as sampled at the previous clock edge. Writes to the clear port do not change them.
- R4: Status bits 3 (framing), 4 (break) and 5 (overrun) are set by a pulse on the matching event input and stay set until cleared.
- R5: A clear write with a 1 at bit 0, 3, 4 or 5 clears that status bit at the next edge. A 0 at a position leaves that bit as it is.
- R6: If a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A control write loads the transmit enable from data bit 5, the receive enable from bit 6 and the error enable from bit 7. Status bit 6 reads 1 exactly when bit 0 and the transmit enable are both set.
- R8: The interrupt output is 1 one cycle after any of these holds: bit 0 with the transmit enable, bit 1 or 2 with the receive enable, or bit 3, 4 or 5 with the error enable. Otherwise it is 0.
- R9: Clearing enables takes the interrupt down but leaves the latched bits pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_thr_sel | input | 2 | Transmit threshold code |
| rx_trig | input | 1 | Receive trigger level reached |
| rx_tmo | input | 1 | Receive inactivity timeout |
| fe_evt | input | 1 | Framing error pulse |
| brk_evt | input | 1 | Break received pulse |
| ovr_evt | input | 1 | Receive overrun pulse |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control data, enables at bits 5..7 |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 7 | Write-one-to-clear mask |
| status | output | 7 | Status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a set and a clear of one sticky bit landing in the same cycle. The other is a transmit request that must not fire again while the level stays at or below the threshold after a clear. The stimulus drives a break pulse and a clear write on the same edge. It then clears the transmit request while the level is held low, and raises the level above the threshold before lowering it again. A reference model in the bench is compared against every field and the interrupt on every cycle.

// File: rtl/uis_pkg.sv
package uis_pkg;

    typedef enum logic [1:0] {
        THR_EMPTY = 2'd0,
        THR_4     = 2'd1,
        THR_8     = 2'd2,
        THR_16    = 2'd3
    } tx_thr_e;

    localparam int ST_TX  = 0;
    localparam int ST_RXT = 1;
    localparam int ST_RXO = 2;
    localparam int ST_FE  = 3;
    localparam int ST_BRK = 4;
    localparam int ST_OVR = 5;
    localparam int ST_TXA = 6;
    localparam int ST_W   = 7;

    localparam int CT_TX  = 5;
    localparam int CT_RX  = 6;
    localparam int CT_ERR = 7;

    localparam int GRP_N  = 3;

    typedef struct packed {
        logic err;
        logic rx;
        logic tx;
    } grp_en_t;

    function automatic int thr_chars(tx_thr_e code);
        case (code)
            THR_EMPTY: return 0;
            THR_4:     return 4;
            THR_8:     return 8;
            default:   return 16;
        endcase
    endfunction

endpackage

// File: rtl/uis_tx_detect.sv
module uis_tx_detect #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       sel,
    output logic             req_evt
);
    import uis_pkg::*;

    logic [LVL_W-1:0] thr_v;
    logic             below;
    logic             below_q;

    assign thr_v   = LVL_W'(thr_chars(tx_thr_e'(sel)));
    assign below   = (level <= thr_v);
    assign req_evt = below & ~below_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            below_q <= 1'b1;
        end else begin
            below_q <= below;
        end
    end
endmodule

// File: rtl/uis_sticky.sv
module uis_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (set_i[i]) begin
                q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uis_irq_combine.sv
module uis_irq_combine #(
    parameter int NG = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NG-1:0] pend,
    input  logic [NG-1:0] en,
    output logic          irq
);
    logic [NG-1:0] gated;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign gated[g] = pend[g] & en[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |gated;
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [1:0]       tx_thr_sel,
    input  logic             rx_trig,
    input  logic             rx_tmo,
    input  logic             fe_evt,
    input  logic             brk_evt,
    input  logic             ovr_evt,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             clr_we,
    input  logic [6:0]       clr_wdata,
    output logic [6:0]       status,
    output logic             irq
);
    import uis_pkg::*;

    localparam int NSTK = 4;

    grp_en_t           en_q;
    logic [1:0]        rx_q;
    logic              tx_evt;
    logic [NSTK-1:0]   stk_set;
    logic [NSTK-1:0]   stk_clr;
    logic [NSTK-1:0]   stk_q;
    logic [GRP_N-1:0]  pend;
    logic              unused_bits;

    assign unused_bits = ^{ctrl_wdata[4:0], clr_wdata[ST_TXA], clr_wdata[ST_RXO:ST_RXT]};

    uis_tx_detect #(.LVL_W(LVL_W)) u_txd (
        .clk     (clk),
        .rst     (rst),
        .level   (tx_level),
        .sel     (tx_thr_sel),
        .req_evt (tx_evt)
    );

    // sticky order: [0]=tx, [1]=fe, [2]=brk, [3]=ovr
    assign stk_set = {ovr_evt, brk_evt, fe_evt, tx_evt};
    assign stk_clr = clr_we ? {clr_wdata[ST_OVR], clr_wdata[ST_BRK],
                               clr_wdata[ST_FE], clr_wdata[ST_TX]}
                            : '0;

    uis_sticky #(.N(NSTK)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .set_i (stk_set),
        .clr_i (stk_clr),
        .q     (stk_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
            en_q <= '0;
        end else begin
            rx_q <= {rx_tmo, rx_trig};
            if (ctrl_we) begin
                en_q <= '{err: ctrl_wdata[CT_ERR], rx: ctrl_wdata[CT_RX], tx: ctrl_wdata[CT_TX]};
            end
        end
    end

    assign status[ST_TX]  = stk_q[0];
    assign status[ST_RXT] = rx_q[0];
    assign status[ST_RXO] = rx_q[1];
    assign status[ST_FE]  = stk_q[1];
    assign status[ST_BRK] = stk_q[2];
    assign status[ST_OVR] = stk_q[3];
    assign status[ST_TXA] = stk_q[0] & en_q.tx;

    assign pend = {|stk_q[3:1], |rx_q, stk_q[0]};

    uis_irq_combine #(.NG(GRP_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .en   (en_q),
        .irq  (irq)
    );
endmodule

// File: rtl/uis_checker.sv
module uis_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_trig,
    input logic       fe_evt,
    input logic       brk_evt,
    input logic       clr_we,
    input logic [6:0] clr_wdata,
    input logic [6:0] status,
    input logic [2:0] en_q,
    input logic       irq
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status == 7'd0 && !irq));

    a_r3_rx_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[1] == $past(rx_trig)));

    a_r4_fe_holds: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !(clr_we && clr_wdata[3])) |=> status[3]);

    a_r5_brk_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_wdata[4] && !brk_evt) |=> !status[4]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        fe_evt |=> status[3]);

    a_r7_txa_gate: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> (status[0] && en_q[0]));

    a_r8_irq_timing: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past((status[0] && en_q[0]) ||
                               ((status[1] || status[2]) && en_q[1]) ||
                               ((status[3] || status[4] || status[5]) && en_q[2]))));
endmodule

bind uart_irq_status uis_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_trig   (rx_trig),
    .fe_evt    (fe_evt),
    .brk_evt   (brk_evt),
    .clr_we    (clr_we),
    .clr_wdata (clr_wdata),
    .status    (status),
    .en_q      (en_q),
    .irq       (irq)
);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] tx_level = '0;
    logic [1:0]    tx_thr_sel = 2'd0;
    logic          rx_trig = 1'b0, rx_tmo = 1'b0;
    logic          fe_evt = 1'b0, brk_evt = 1'b0, ovr_evt = 1'b0;
    logic          ctrl_we = 1'b0, clr_we = 1'b0;
    logic [7:0]    ctrl_wdata = '0;
    logic [6:0]    clr_wdata = '0;
    logic [6:0]    status;
    logic          irq;

    int total = 0, bad = 0;
    bit finished = 0;

    bit [6:0] m_st = '0;
    bit [2:0] m_en = '0;
    bit       m_irq = 0;
    bit       m_prevb = 1;

    always #2 clk = ~clk;

    uart_irq_status #(.LVL_W(LW)) dut (
        .clk(clk), .rst(rst), .tx_level(tx_level), .tx_thr_sel(tx_thr_sel),
        .rx_trig(rx_trig), .rx_tmo(rx_tmo), .fe_evt(fe_evt), .brk_evt(brk_evt),
        .ovr_evt(ovr_evt), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .status(status), .irq(irq)
    );

    function automatic int thr_of(bit [1:0] s);
        return (s == 0) ? 0 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model the edge from the inputs now driven, then compare all fields
    task automatic cyc();
        bit below, ev, clr;
        bit [6:0] n;
        bit [2:0] ne;
        bit ni;
        below = (int'(tx_level) <= thr_of(tx_thr_sel));
        ev    = below && !m_prevb;
        n[0]  = ev      | (m_st[0] & !(clr_we & clr_wdata[0]));
        n[1]  = rx_trig;
        n[2]  = rx_tmo;
        n[3]  = fe_evt  | (m_st[3] & !(clr_we & clr_wdata[3]));
        n[4]  = brk_evt | (m_st[4] & !(clr_we & clr_wdata[4]));
        n[5]  = ovr_evt | (m_st[5] & !(clr_we & clr_wdata[5]));
        ne    = ctrl_we ? {ctrl_wdata[7], ctrl_wdata[6], ctrl_wdata[5]} : m_en;
        n[6]  = n[0] & ne[0];
        ni    = (m_st[0] & m_en[0]) | ((m_st[1] | m_st[2]) & m_en[1]) |
                ((m_st[3] | m_st[4] | m_st[5]) & m_en[2]);
        @(posedge clk);
        m_st = n; m_en = ne; m_irq = ni; m_prevb = below;
        @(negedge clk);
        chk("R2 tx request bit", int'(status[0]), int'(m_st[0]));
        chk("R3 rx level bits", int'(status[2:1]), int'(m_st[2:1]));
        chk("R4 error bits", int'(status[5:3]), int'(m_st[5:3]));
        chk("R7 tx interrupt set bit", int'(status[6]), int'(m_st[6]));
        chk("R8 irq output", int'(irq), int'(m_irq));
        fe_evt = 0; brk_evt = 0; ovr_evt = 0; ctrl_we = 0; clr_we = 0;
    endtask

    task automatic wclr(input bit [6:0] d);
        clr_we = 1; clr_wdata = d;
    endtask

    task automatic wctl(input bit [7:0] d);
        ctrl_we = 1; ctrl_wdata = d;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tx_level = 7'd30;
        tx_thr_sel = 2'd1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 status after reset", int'(status), 0);
        chk("R1 irq after reset", int'(irq), 0);
        rst = 0;
        m_prevb = 0; // level 30 sampled at reset edge? model: reset forces previous-below to 1
        m_prevb = 1;
        cyc(); // level 30 above threshold 4: no request, prev becomes above

        // R2: fall to threshold 4
        tx_level = 7'd10; cyc();
        tx_level = 7'd5;  cyc();
        chk("R2 not yet at 5", int'(status[0]), 0);
        tx_level = 7'd4;  cyc();
        chk("R2 set at level 4", int'(status[0]), 1);
        tx_level = 7'd2;  cyc();
        // R5: clear while level stays low: no re-trigger
        wclr(7'h01); cyc();
        chk("R5 tx bit cleared", int'(status[0]), 0);
        cyc(); cyc();
        chk("R2 no retrigger while low", int'(status[0]), 0);
        // threshold empty (code 0)
        tx_thr_sel = 2'd0; tx_level = 7'd3; cyc();
        chk("R2 level 3 above empty", int'(status[0]), 0);
        tx_level = 7'd0; cyc();
        chk("R2 set at empty", int'(status[0]), 1);
        wclr(7'h01); cyc();
        // threshold 16 (code 3)
        tx_thr_sel = 2'd3; tx_level = 7'd40; cyc();
        tx_level = 7'd17; cyc();
        chk("R2 17 above 16", int'(status[0]), 0);
        tx_level = 7'd16; cyc();
        chk("R2 set at 16", int'(status[0]), 1);
        wclr(7'h01); cyc();

        // R3: receive level bits follow and ignore clears
        rx_trig = 1; cyc();
        chk("R3 trigger bit", int'(status[1]), 1);
        rx_tmo = 1; wclr(7'h06); cyc();
        chk("R3 clear ignored", int'(status[2:1]), 3);
        rx_trig = 0; rx_tmo = 0; cyc();
        chk("R3 drops with condition", int'(status[2:1]), 0);

        // R4 / R5: framing sticky, zero write no effect, then clear
        fe_evt = 1; cyc();
        cyc(); cyc();
        chk("R4 framing sticky", int'(status[3]), 1);
        wclr(7'h00); cyc();
        chk("R5 zero write no effect", int'(status[3]), 1);
        ovr_evt = 1; cyc();
        wclr(7'h08); cyc();
        chk("R5 framing cleared", int'(status[3]), 0);
        chk("R5 overrun kept", int'(status[5]), 1);
        wclr(7'h20); cyc();

        // R6: set and clear together
        brk_evt = 1; wclr(7'h10); cyc();
        chk("R6 set wins", int'(status[4]), 1);

        // R7 / R8: enables
        wctl(8'h80); cyc();
        cyc();
        chk("R8 error irq", int'(irq), 1);
        wclr(7'h10); cyc(); cyc();
        chk("R8 irq falls after clear", int'(irq), 0);
        tx_thr_sel = 2'd2; tx_level = 7'd20; cyc();
        tx_level = 7'd8; wctl(8'h20); cyc();
        chk("R7 tx interrupt set", int'(status[6]), 1);
        cyc();
        chk("R8 tx irq", int'(irq), 1);
        rx_trig = 1; fe_evt = 1; wctl(8'hE0); cyc(); cyc();
        // R9: drop all enables, latched bits remain
        wctl(8'h1F); cyc(); cyc();
        chk("R9 irq off", int'(irq), 0);
        chk("R9 bits pending", int'(status[3]) + int'(status[0]), 2);
        chk("R7 tx set bit off", int'(status[6]), 0);
        rx_trig = 0; cyc();

        // R1: reset mid-run
        rst = 1; @(posedge clk); @(negedge clk);
        chk("R1 reset again", int'(status), 0);
        chk("R1 irq reset again", int'(irq), 0);
        rst = 0; m_st = '0; m_en = '0; m_irq = 0; m_prevb = 1;
        cyc();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule